// File: doc/BRIEF.md
# Breakpoint Trigger Configuration and Gating

This block sits beside two condition detectors, one comparing a digital word and one comparing a converted analog sample, and turns their per-cycle valid flags into a single breakpoint signal. A small configuration register sits in the test access port data path. It holds the operation code for each detector and a two-bit trigger selector. Scan strobes from an external TAP controller fill and commit this register while the configuration-select instruction is loaded.

The block also decodes the instruction register. Three comparison instructions assert an inhibit that stops the detectors' limit registers from being overwritten on Update-DR. The same three instructions arm the trigger, but only while the TAP state is Run-Test/Idle. Once armed, the selector picks one of four sources for the valid-condition output: the digital flag, the analog flag, their AND, or their OR. The output is registered one TCK cycle after its inputs. It is low whenever the trigger is not armed, so a target clock gated by its inverse keeps running.

There is no streaming data path. Every pin is a plain control or status level, sampled on the rising TCK edge.

Top module: `breakpoint_trigger_ctl`

## Requirements
- R1: After the active-low reset, the committed configuration is all zeros: both operation codes read 000, the selector reads 00, and the valid-condition output is low.
- R2: While the configuration-select instruction (default 0Ah) is loaded, a Capture-DR strobe clears the 8-bit shift stage to 8'h00, so the scan output reads 0.
- R3: While the configuration-select instruction is loaded, each Shift-DR strobe moves the shift stage one place toward the scan output. The scan input enters bit 7 and the scan output always shows bit 0, so the k-th bit shifted in (k = 0..7) ends in bit k.
- R4: An Update-DR strobe under the configuration-select instruction copies the shift stage into the committed copy. Bits 7:5 drive the digital operation code, bits 4:2 the analog operation code, and bits 1:0 the trigger selector.
- R5: Capture, shift and update strobes have no effect on the shift stage or the committed copy while any other instruction is loaded.
- R6: The update-inhibit output is high exactly when the instruction register holds one of the three comparison opcodes: 07h, 08h and 09h by default. It is low for every other value, including the configuration-select opcode.
- R7: The trigger is armed only when a comparison opcode is loaded and the TAP state equals 4'hC (Run-Test/Idle). At any rising edge where it is not armed, the valid-condition output goes low on that edge.
- R8: When armed, selector 01 passes the analog flag and selector 00 passes the digital flag. Selector 10 gives the AND of the two flags, and selector 11 gives their OR.
- R9: The valid-condition output after a rising edge reflects the instruction, TAP state, flags and committed selector sampled at that edge. It has exactly one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low reset |
| ir_value | input | 8 | Current instruction register contents |
| tap_state | input | 4 | Encoded TAP controller state |
| capture_dr | input | 1 | Capture-DR strobe |
| shift_dr | input | 1 | Shift-DR strobe |
| update_dr | input | 1 | Update-DR strobe |
| scan_in | input | 1 | Serial data from TDI |
| scan_out | output | 1 | Serial data toward TDO (bit 0 of shift stage) |
| ana_valid | input | 1 | Analog detector valid flag |
| dig_valid | input | 1 | Digital detector valid flag |
| dig_opcode | output | 3 | Operation code for the digital detector |
| ana_opcode | output | 3 | Operation code for the analog detector |
| upd_inhibit | output | 1 | Suppresses detector update strobes |
| vc_out | output | 1 | Registered valid-condition output |

## Verification
On every cycle, the assertions check the following:
- The output drops after any unarmed edge.
- Each selector setting maps the flags correctly one cycle later.
- Capture clears the shift stage.
- The committed copy stays put without a selected update.
- The decoder never claims both a comparison and the configuration instruction.

Some behaviour only the bench's scenarios can show. These are the serial bit order from scan input to the opcode fields, and that strobes under a foreign instruction leave the visible opcodes unchanged. They also include the full sweep of opcode and state values against the inhibit and arming decode.

// File: rtl/bpt_pkg.sv
package bpt_pkg;

  typedef enum logic [1:0] {
    TRIG_DIG = 2'b00,
    TRIG_ANA = 2'b01,
    TRIG_AND = 2'b10,
    TRIG_OR  = 2'b11
  } trig_sel_e;

  typedef struct packed {
    logic [2:0] dig_op;
    logic [2:0] ana_op;
    trig_sel_e  sel;
  } trig_cfg_t;

  localparam int CFG_BITS = $bits(trig_cfg_t);

endpackage

// File: rtl/bpt_instr_decode.sv
module bpt_instr_decode #(
  parameter int          IR_W      = 8,
  parameter int          STATE_W   = 4,
  parameter int          N_CMP     = 3,
  parameter logic [IR_W*N_CMP-1:0] CMP_OPS = {8'h09, 8'h08, 8'h07},
  parameter logic [IR_W-1:0]  CFG_OP   = 8'h0A,
  parameter logic [STATE_W-1:0] IDLE_ST = 4'hC
) (
  input  logic               tck,
  input  logic               trst_n,
  input  logic [IR_W-1:0]    ir_value,
  input  logic [STATE_W-1:0] tap_state,
  output logic               is_cmp,
  output logic               cfg_sel,
  output logic               armed
);

  logic [N_CMP-1:0] hit;

  for (genvar g = 0; g < N_CMP; g++) begin : g_cmp
    assign hit[g] = (ir_value == CMP_OPS[g*IR_W +: IR_W]);
  end

  assign is_cmp  = |hit;
  assign cfg_sel = (ir_value == CFG_OP);
  assign armed   = is_cmp && (tap_state == IDLE_ST);

  // R6
  excl_decode_chk: assert property (@(posedge tck) disable iff (!trst_n)
    $onehot0({is_cmp, cfg_sel}));

endmodule

// File: rtl/bpt_cfg_scan.sv
module bpt_cfg_scan
  import bpt_pkg::*;
(
  input  logic      tck,
  input  logic      trst_n,
  input  logic      selected,
  input  logic      capture_dr,
  input  logic      shift_dr,
  input  logic      update_dr,
  input  logic      scan_in,
  output logic      scan_out,
  output trig_cfg_t cfg
);

  logic [CFG_BITS-1:0] shift_q;
  logic [CFG_BITS-1:0] shadow_q;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      shift_q <= '0;
    end else if (selected && capture_dr) begin
      shift_q <= '0;
    end else if (selected && shift_dr) begin
      shift_q <= {scan_in, shift_q[CFG_BITS-1:1]};
    end
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      shadow_q <= '0;
    end else if (selected && update_dr) begin
      shadow_q <= shift_q;
    end
  end

  assign scan_out = shift_q[0];
  assign cfg      = trig_cfg_t'(shadow_q);

  // R2
  capture_clear_chk: assert property (@(posedge tck) disable iff (!trst_n)
    selected && capture_dr |=> shift_q == '0);

  // R3
  shift_move_chk: assert property (@(posedge tck) disable iff (!trst_n)
    selected && shift_dr && !capture_dr |=> scan_out == $past(shift_q[1]));

  // R5
  shadow_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
    !(selected && update_dr) |=> $stable(shadow_q));

endmodule

// File: rtl/bpt_trig_combine.sv
module bpt_trig_combine
  import bpt_pkg::*;
(
  input  logic      tck,
  input  logic      trst_n,
  input  logic      armed,
  input  trig_sel_e sel,
  input  logic      ana_valid,
  input  logic      dig_valid,
  output logic      vc_out
);

  logic pick;
  logic vc_q;

  always_comb begin
    unique case (sel)
      TRIG_DIG: pick = dig_valid;
      TRIG_ANA: pick = ana_valid;
      TRIG_AND: pick = ana_valid & dig_valid;
      TRIG_OR:  pick = ana_valid | dig_valid;
      default:  pick = 1'b0;
    endcase
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) vc_q <= 1'b0;
    else         vc_q <= armed & pick;
  end

  assign vc_out = vc_q;

  // R7
  unarmed_low_chk: assert property (@(posedge tck) disable iff (!trst_n)
    !armed |=> !vc_out);

  // R8
  ana_only_chk: assert property (@(posedge tck) disable iff (!trst_n)
    armed && sel == TRIG_ANA |=> vc_out == $past(ana_valid));

  // R8
  dig_only_chk: assert property (@(posedge tck) disable iff (!trst_n)
    armed && sel == TRIG_DIG |=> vc_out == $past(dig_valid));

  // R8
  and_mode_chk: assert property (@(posedge tck) disable iff (!trst_n)
    armed && sel == TRIG_AND |=> vc_out == ($past(ana_valid) && $past(dig_valid)));

  // R8
  or_mode_chk: assert property (@(posedge tck) disable iff (!trst_n)
    armed && sel == TRIG_OR |=> vc_out == ($past(ana_valid) || $past(dig_valid)));

endmodule

// File: rtl/breakpoint_trigger_ctl.sv
module breakpoint_trigger_ctl
  import bpt_pkg::*;
#(
  parameter int             IR_W      = 8,
  parameter int             STATE_W   = 4,
  parameter logic [IR_W-1:0] PROBE_OP  = 8'h07,
  parameter logic [IR_W-1:0] CMP_A_OP  = 8'h08,
  parameter logic [IR_W-1:0] CMP_B_OP  = 8'h09,
  parameter logic [IR_W-1:0] CFG_OP    = 8'h0A,
  parameter logic [STATE_W-1:0] IDLE_ST = 4'hC
) (
  input  logic               tck,
  input  logic               trst_n,
  input  logic [IR_W-1:0]    ir_value,
  input  logic [STATE_W-1:0] tap_state,
  input  logic               capture_dr,
  input  logic               shift_dr,
  input  logic               update_dr,
  input  logic               scan_in,
  output logic               scan_out,
  input  logic               ana_valid,
  input  logic               dig_valid,
  output logic [2:0]         dig_opcode,
  output logic [2:0]         ana_opcode,
  output logic               upd_inhibit,
  output logic               vc_out
);

  localparam int N_CMP = 3;
  localparam logic [IR_W*N_CMP-1:0] CMP_OPS = {CMP_B_OP, CMP_A_OP, PROBE_OP};

  logic      is_cmp;
  logic      cfg_sel;
  logic      armed;
  trig_cfg_t cfg;

  bpt_instr_decode #(
    .IR_W    (IR_W),
    .STATE_W (STATE_W),
    .N_CMP   (N_CMP),
    .CMP_OPS (CMP_OPS),
    .CFG_OP  (CFG_OP),
    .IDLE_ST (IDLE_ST)
  ) i_decode (
    .tck       (tck),
    .trst_n    (trst_n),
    .ir_value  (ir_value),
    .tap_state (tap_state),
    .is_cmp    (is_cmp),
    .cfg_sel   (cfg_sel),
    .armed     (armed)
  );

  bpt_cfg_scan i_scan (
    .tck        (tck),
    .trst_n     (trst_n),
    .selected   (cfg_sel),
    .capture_dr (capture_dr),
    .shift_dr   (shift_dr),
    .update_dr  (update_dr),
    .scan_in    (scan_in),
    .scan_out   (scan_out),
    .cfg        (cfg)
  );

  bpt_trig_combine i_combine (
    .tck       (tck),
    .trst_n    (trst_n),
    .armed     (armed),
    .sel       (cfg.sel),
    .ana_valid (ana_valid),
    .dig_valid (dig_valid),
    .vc_out    (vc_out)
  );

  assign dig_opcode  = cfg.dig_op;
  assign ana_opcode  = cfg.ana_op;
  assign upd_inhibit = is_cmp;

  // R9
  latency_chk: assert property (@(posedge tck) disable iff (!trst_n)
    armed && ana_valid && dig_valid |=> vc_out);

endmodule

// File: tb/test_breakpoint_trigger_ctl.sv
module test_breakpoint_trigger_ctl;

  logic       tck = 1'b0;
  logic       trst_n = 1'b0;
  logic [7:0] ir_value = 8'h00;
  logic [3:0] tap_state = 4'h0;
  logic       capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0;
  logic       scan_in = 1'b0, ana_valid = 1'b0, dig_valid = 1'b0;
  logic       scan_out, upd_inhibit, vc_out;
  logic [2:0] dig_opcode, ana_opcode;

  int checks = 0;
  int fails  = 0;
  string cur_req = "R1";

  // reference state
  bit   ref_sh[$];
  byte  ref_cfg = 8'h00;
  bit   ref_vc = 1'b0;

  always #10 tck = ~tck;

  breakpoint_trigger_ctl i_breakpoint_trigger_ctl (
    .tck(tck), .trst_n(trst_n), .ir_value(ir_value), .tap_state(tap_state),
    .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
    .scan_in(scan_in), .scan_out(scan_out), .ana_valid(ana_valid),
    .dig_valid(dig_valid), .dig_opcode(dig_opcode), .ana_opcode(ana_opcode),
    .upd_inhibit(upd_inhibit), .vc_out(vc_out)
  );

  function automatic bit ref_is_cmp(logic [7:0] ir);
    return (ir == 8'h07) || (ir == 8'h08) || (ir == 8'h09);
  endfunction

  function automatic bit ref_pick(byte c, bit a, bit d);
    case (c[1:0])
      2'b00:   return d;
      2'b01:   return a;
      2'b10:   return a & d;
      default: return a | d;
    endcase
  endfunction

  task automatic ref_reset();
    ref_sh.delete();
    for (int i = 0; i < 8; i++) ref_sh.push_back(1'b0);
    ref_cfg = 8'h00;
    ref_vc  = 1'b0;
  endtask

  initial ref_reset();

  always @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      ref_reset();
    end else begin
      bit sel_cfg;
      byte packed_sh;
      ref_vc = ref_is_cmp(ir_value) && (tap_state == 4'hC) &&
               ref_pick(ref_cfg, ana_valid, dig_valid);
      sel_cfg = (ir_value == 8'h0A);
      packed_sh = 0;
      for (int i = 0; i < 8; i++) packed_sh[i] = ref_sh[i];
      if (sel_cfg && update_dr) ref_cfg = packed_sh;
      if (sel_cfg && capture_dr) begin
        for (int i = 0; i < 8; i++) ref_sh[i] = 1'b0;
      end else if (sel_cfg && shift_dr) begin
        void'(ref_sh.pop_front());
        ref_sh.push_back(scan_in);
      end
    end
  end

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // cycle-by-cycle comparison
  always @(negedge tck) begin
    if (trst_n) begin
      chk(cur_req, "vc_out", vc_out, ref_vc);
      chk(cur_req, "upd_inhibit", upd_inhibit, ref_is_cmp(ir_value));
      chk(cur_req, "scan_out", scan_out, ref_sh[0]);
      chk(cur_req, "dig_opcode", dig_opcode, ref_cfg[7:5]);
      chk(cur_req, "ana_opcode", ana_opcode, ref_cfg[4:2]);
    end
  end

  task automatic step();
    @(posedge tck);
    #2;
  endtask

  task automatic scan_cfg(logic [7:0] ir, logic [7:0] v);
    ir_value = ir;
    tap_state = 4'h2;
    capture_dr = 1'b1;
    step();
    capture_dr = 1'b0;
    for (int i = 0; i < 8; i++) begin
      shift_dr = 1'b1;
      scan_in  = v[i];
      step();
    end
    shift_dr = 1'b0;
    update_dr = 1'b1;
    step();
    update_dr = 1'b0;
    step();
  endtask

  task automatic scenario();
    step(); step();
    cur_req = "R1";
    @(negedge tck);
    chk("R1", "reset dig_opcode", dig_opcode, 0);
    chk("R1", "reset ana_opcode", ana_opcode, 0);
    chk("R1", "reset vc_out", vc_out, 0);
    trst_n = 1'b1;
    step();

    // R2 / R3: fill shift stage with ones, then capture clears
    cur_req = "R3";
    ir_value = 8'h0A;
    for (int i = 0; i < 8; i++) begin
      shift_dr = 1'b1; scan_in = 1'b1; step();
    end
    shift_dr = 1'b0;
    @(negedge tck);
    chk("R3", "scan_out after ones", scan_out, 1);
    step();
    cur_req = "R2";
    capture_dr = 1'b1; step(); capture_dr = 1'b0;
    @(negedge tck);
    chk("R2", "scan_out after capture", scan_out, 0);
    step();

    // R4: load dig=101 ana=110 sel=01
    cur_req = "R4";
    scan_cfg(8'h0A, 8'b101_110_01);
    @(negedge tck);
    chk("R4", "dig_opcode field", dig_opcode, 3'b101);
    chk("R4", "ana_opcode field", ana_opcode, 3'b110);
    step();

    // R5: strobes under foreign instructions
    cur_req = "R5";
    scan_cfg(8'h07, 8'b010_001_11);
    scan_cfg(8'h05, 8'b011_011_10);
    @(negedge tck);
    chk("R5", "dig_opcode held", dig_opcode, 3'b101);
    chk("R5", "ana_opcode held", ana_opcode, 3'b110);
    step();

    // R6: inhibit decode sweep
    cur_req = "R6";
    for (int v = 0; v < 20; v++) begin
      ir_value = v[7:0]; step();
    end
    ir_value = 8'hFF; step();

    // R7/R8/R9: each selector with all flag combos, armed and not
    for (int s = 0; s < 4; s++) begin
      cur_req = "R8";
      scan_cfg(8'h0A, {3'b000, 3'b111, s[1:0]});
      for (int op = 0; op < 5; op++) begin
        ir_value = (op == 0) ? 8'h07 : (op == 1) ? 8'h08 : (op == 2) ? 8'h09 :
                   (op == 3) ? 8'h0A : 8'h06;
        for (int st = 0; st < 3; st++) begin
          tap_state = (st == 0) ? 4'hC : (st == 1) ? 4'hD : 4'h4;
          cur_req = (op < 3 && st == 0) ? "R8" : "R7";
          for (int f = 0; f < 4; f++) begin
            ana_valid = f[1]; dig_valid = f[0];
            step();
          end
        end
      end
    end

    // R9: single-cycle pulse, analog-only mode
    cur_req = "R9";
    scan_cfg(8'h0A, 8'b000_000_01);
    ir_value = 8'h07; tap_state = 4'hC; ana_valid = 1'b0; dig_valid = 1'b0;
    step();
    ana_valid = 1'b1; step();
    @(negedge tck);
    chk("R9", "vc_out one cycle after flag", vc_out, 1);
    ana_valid = 1'b0; step();
    @(negedge tck);
    chk("R9", "vc_out drops one cycle later", vc_out, 0);
    tap_state = 4'h1; ana_valid = 1'b1; step();
    @(negedge tck);
    chk("R7", "leaving idle clears vc_out", vc_out, 0);
    step();
  endtask

  initial begin
    fork
      scenario();
      begin
        repeat (100000) @(posedge tck);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule